// File: doc/BRIEF.md
# MII Transmit Nibble Framer

This block turns a byte-wide frame stream into the 4-bit transmit side of a media-independent interface. It runs entirely in the transmit clock domain supplied by the PHY. A source offers frame bytes with valid, last and error flags. The framer opens each frame with a run of preamble nibbles and a start-of-frame delimiter. It then sends every byte as two nibbles, low half first. It keeps the enable line high for exactly the length of the frame.

The block always ends a frame on a whole byte, even when the source stalls mid-frame. In that case the rest of the byte goes out flagged as errored, and the frame closes at the byte boundary. A line-watching timer enforces the inter-frame gap before the next frame may begin. CRC, padding, collision handling and the receive side belong to other blocks.

Top module: `mii_tx_framer`

## Requirements
- R1: After reset, and whenever phy_en is low, phy_nib is 0 and phy_err is 0. No frame starts while src_valid is low.
- R2: Every frame opens with PRE_NIBS (default 15) nibbles of value 0x5 and then one nibble of value 0xD. phy_en rises together with the first 0x5 nibble.
- R3: After the delimiter, each source word is sent least significant nibble first: bits [3:0], then [7:4] (and further nibbles upward for wider words).
- R4: phy_en stays high for exactly PRE_NIBS+1 nibbles plus DATA_W/4 nibbles per word. It falls in the cycle right after the last nibble of the word that carried src_last.
- R5: src_ready is high only while src_valid is high, and only in the cycle in which the framer takes the final (high) nibble of the current word. It is never high during preamble, delimiter or idle.
- R6: When src_err is high with a word, phy_err is high on every nibble of that word and low on the nibbles of clean words.
- R7: If src_valid is low when a new word is due mid-frame, the framer sends one full word of 0x0 nibbles with phy_err high and then ends the frame.
- R8: If src_valid drops after a word's low nibble has been sent, the remaining nibbles of that word go out as 0x0 with phy_err high, and the frame ends on that word boundary. No frame carries a partial word.
- R9: Between frames, phy_en stays low for at least IFG_CYCLES (default 24) cycles. When the next frame is already waiting, the gap is exactly IFG_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock from the PHY |
| rst_n | input | 1 | Active-low synchronous reset |
| src_data | input | DATA_W | Frame word from the source |
| src_valid | input | 1 | src_data, src_last and src_err are valid |
| src_last | input | 1 | Current word is the last of the frame |
| src_err | input | 1 | Current word is to be flagged as errored |
| src_ready | output | 1 | Word is taken at this clock edge |
| phy_nib | output | 4 | Nibble to the PHY |
| phy_en | output | 1 | Frame in progress on phy_nib |
| phy_err | output | 1 | Current nibble is errored |

## Verification
The bench goes after the two underrun points: a stall at a word boundary and a stall between a word's two nibbles. A design that mishandled either would leave an odd nibble count on the line or send stale data without phy_err. Single-byte frames and frames whose last byte is errored test whether phy_en falls one nibble early or late, and whether the error flag leaks into the next frame. Back-to-back frames with the source already waiting pin the gap to exactly 24 cycles, so a timer that is off by one in either direction shows up. A ready pulse landing on a low nibble would shift every byte by half and corrupt the nibble order check.

// File: rtl/mii_tx_pkg.sv
`timescale 1ns/1ps
package mii_tx_pkg;

   localparam int NIB_W = 4;

   localparam logic [NIB_W-1:0] NIB_PREAMBLE = 4'h5;
   localparam logic [NIB_W-1:0] NIB_SFD      = 4'hD;
   localparam logic [NIB_W-1:0] NIB_IDLE     = 4'h0;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PRE,
      ST_DATA,
      ST_FILL
   } seq_state_t;

endpackage

// File: rtl/mii_tx_nibble_sel.sv
`timescale 1ns/1ps
module mii_tx_nibble_sel #(
   parameter int DATA_W = 8,
   localparam int NPW   = DATA_W / 4,
   localparam int IDX_W = (NPW > 1) ? $clog2(NPW) : 1
) (
   input  logic [DATA_W-1:0] word,
   input  logic [IDX_W-1:0]  idx,
   output logic [3:0]        nib
);

   generate
      if (NPW == 2) begin : g_pair
         assign nib = idx[0] ? word[7:4] : word[3:0];
      end else begin : g_wide
         logic [3:0] parts [NPW];
         for (genvar g = 0; g < NPW; g++) begin : g_part
            assign parts[g] = word[g*4 +: 4];
         end
         assign nib = parts[idx];
      end
   endgenerate

endmodule

// File: rtl/mii_tx_gap_timer.sv
`timescale 1ns/1ps
module mii_tx_gap_timer #(
   parameter int IFG_CYCLES = 24
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_active,
   output logic gap_ok
);

   generate
      if (IFG_CYCLES == 1) begin : g_single
         assign gap_ok = !line_active;
      end else begin : g_count
         localparam int CNT_W = $clog2(IFG_CYCLES);
         localparam logic [CNT_W-1:0] SAT = CNT_W'(IFG_CYCLES - 1);
         logic [CNT_W-1:0] quiet_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               quiet_q <= SAT;
            end else if (line_active) begin
               quiet_q <= '0;
            end else if (quiet_q != SAT) begin
               quiet_q <= quiet_q + 1'b1;
            end
         end

         assign gap_ok = !line_active && (quiet_q == SAT);
      end
   endgenerate

endmodule

// File: rtl/mii_tx_seq.sv
`timescale 1ns/1ps
module mii_tx_seq
   import mii_tx_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int PRE_NIBS = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gap_ok,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_valid,
   input  logic              src_last,
   input  logic              src_err,
   output logic              src_ready,
   output logic [3:0]        phy_nib,
   output logic              phy_en,
   output logic              phy_err
);

   localparam int NPW   = DATA_W / 4;
   localparam int IDX_W = (NPW > 1) ? $clog2(NPW) : 1;
   localparam int PRE_W = $clog2(PRE_NIBS + 1);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPW - 1);
   localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_NIBS);

   seq_state_t        state_q;
   logic [PRE_W-1:0]  pre_q;
   logic [IDX_W-1:0]  idx_q;
   logic [3:0]        nib_q;
   logic              en_q;
   logic              er_q;
   logic              werr_q;
   logic [3:0]        cur_nib;
   logic              at_last;
   logic              word_err;

   mii_tx_nibble_sel #(.DATA_W(DATA_W)) u_sel (
      .word (src_data),
      .idx  (idx_q),
      .nib  (cur_nib)
   );

   assign at_last  = (idx_q == LAST_IDX);
   assign word_err = src_err | ((idx_q != '0) & werr_q);

   always_comb begin
      src_ready = (state_q == ST_DATA) && at_last && src_valid;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pre_q   <= '0;
         idx_q   <= '0;
         nib_q   <= NIB_IDLE;
         en_q    <= 1'b0;
         er_q    <= 1'b0;
         werr_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               nib_q  <= NIB_IDLE;
               en_q   <= 1'b0;
               er_q   <= 1'b0;
               werr_q <= 1'b0;
               if (src_valid && gap_ok) begin
                  state_q <= ST_PRE;
                  nib_q   <= NIB_PREAMBLE;
                  en_q    <= 1'b1;
                  pre_q   <= PRE_W'(1);
               end
            end
            ST_PRE: begin
               er_q <= 1'b0;
               if (pre_q == PRE_LAST) begin
                  nib_q   <= NIB_SFD;
                  idx_q   <= '0;
                  state_q <= ST_DATA;
               end else begin
                  nib_q <= NIB_PREAMBLE;
                  pre_q <= pre_q + 1'b1;
               end
            end
            ST_DATA: begin
               if (src_valid) begin
                  nib_q  <= cur_nib;
                  er_q   <= word_err;
                  werr_q <= word_err;
                  if (at_last) begin
                     idx_q <= '0;
                     if (src_last) begin
                        state_q <= ST_IDLE;
                     end
                  end else begin
                     idx_q <= idx_q + 1'b1;
                  end
               end else begin
                  nib_q <= NIB_IDLE;
                  er_q  <= 1'b1;
                  if (at_last) begin
                     state_q <= ST_IDLE;
                  end else begin
                     state_q <= ST_FILL;
                     idx_q   <= idx_q + 1'b1;
                  end
               end
            end
            ST_FILL: begin
               nib_q <= NIB_IDLE;
               er_q  <= 1'b1;
               if (at_last) begin
                  state_q <= ST_IDLE;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: begin
               state_q <= ST_IDLE;
            end
         endcase
      end
   end

   assign phy_nib = nib_q;
   assign phy_en  = en_q;
   assign phy_err = er_q;

endmodule

// File: rtl/mii_tx_framer.sv
`timescale 1ns/1ps
module mii_tx_framer #(
   parameter int DATA_W     = 8,
   parameter int PRE_NIBS   = 15,
   parameter int IFG_CYCLES = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_valid,
   input  logic              src_last,
   input  logic              src_err,
   output logic              src_ready,
   output logic [3:0]        phy_nib,
   output logic              phy_en,
   output logic              phy_err
);

   generate
      if ((DATA_W % 4) != 0 || DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be a multiple of 4 and at least 8");
      end
      if (PRE_NIBS < 1) begin : g_bad_pre
         $error("PRE_NIBS must be at least 1");
      end
      if (IFG_CYCLES < 1) begin : g_bad_ifg
         $error("IFG_CYCLES must be at least 1");
      end
   endgenerate

   logic gap_ok;

   mii_tx_gap_timer #(.IFG_CYCLES(IFG_CYCLES)) u_gap (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_active (phy_en),
      .gap_ok      (gap_ok)
   );

   mii_tx_seq #(.DATA_W(DATA_W), .PRE_NIBS(PRE_NIBS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .gap_ok    (gap_ok),
      .src_data  (src_data),
      .src_valid (src_valid),
      .src_last  (src_last),
      .src_err   (src_err),
      .src_ready (src_ready),
      .phy_nib   (phy_nib),
      .phy_en    (phy_en),
      .phy_err   (phy_err)
   );

endmodule

// File: rtl/mii_tx_framer_chk.sv
`timescale 1ns/1ps
module mii_tx_framer_chk #(
   parameter int DATA_W     = 8,
   parameter int PRE_NIBS   = 15,
   parameter int IFG_CYCLES = 24
) (
   input logic       clk,
   input logic       rst_n,
   input logic       src_valid,
   input logic       src_ready,
   input logic [3:0] phy_nib,
   input logic       phy_en,
   input logic       phy_err
);

   localparam int NPW  = DATA_W / 4;
   localparam int HEAD = PRE_NIBS + 1;

   logic [31:0] en_cnt;
   logic [31:0] low_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_cnt  <= '0;
         low_cnt <= 32'(IFG_CYCLES);
      end else if (phy_en) begin
         en_cnt  <= en_cnt + 1'b1;
         low_cnt <= '0;
      end else begin
         en_cnt <= '0;
         if (low_cnt < 32'(IFG_CYCLES)) begin
            low_cnt <= low_cnt + 1'b1;
         end
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !phy_en |-> (phy_nib == 4'h0 && !phy_err)); // R1

   AST_FIRST_PREAMBLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_en) |-> (phy_nib == 4'h5 && !phy_err)); // R2

   AST_READY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      src_ready |-> (src_valid && phy_en)); // R5

   AST_WHOLE_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(phy_en) |-> (en_cnt >= 32'(HEAD + NPW) &&
                         ((en_cnt - 32'(HEAD)) % 32'(NPW)) == 0)); // R4

   AST_MIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(phy_en) |-> (low_cnt >= 32'(IFG_CYCLES))); // R9

endmodule

bind mii_tx_framer mii_tx_framer_chk #(
   .DATA_W     (DATA_W),
   .PRE_NIBS   (PRE_NIBS),
   .IFG_CYCLES (IFG_CYCLES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_valid (src_valid),
   .src_ready (src_ready),
   .phy_nib   (phy_nib),
   .phy_en    (phy_en),
   .phy_err   (phy_err)
);

// File: tb/test_mii_tx_framer.sv
`timescale 1ns/1ps
module test_mii_tx_framer;

   localparam int IFG  = 24;
   localparam int PRE  = 15;
   localparam int HEAD = PRE + 1;

   logic       clk;
   logic       rst_n;
   logic [7:0] src_data;
   logic       src_valid;
   logic       src_last;
   logic       src_err;
   logic       src_ready;
   logic [3:0] phy_nib;
   logic       phy_en;
   logic       phy_err;

   mii_tx_framer i_mii_tx_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_data  (src_data),
      .src_valid (src_valid),
      .src_last  (src_last),
      .src_err   (src_err),
      .src_ready (src_ready),
      .phy_nib   (phy_nib),
      .phy_en    (phy_en),
      .phy_err   (phy_err)
   );

   initial begin
      clk = 1'b0;
      forever #2 clk = ~clk;
   end

   int   n_checks = 0;
   int   n_fail   = 0;
   bit   done     = 1'b0;

   logic [3:0] exp_nib [$];
   bit         exp_er  [$];
   logic [3:0] cap_nib [$];
   bit         cap_er  [$];

   int frames_done = 0;
   int low_run     = 1000;
   int last_gap    = 0;
   int idle_bad    = 0;
   int ready_bad   = 0;
   bit prev_en     = 1'b0;
   bit prev_ready  = 1'b0;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // line monitor, samples away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (phy_en) begin
            if (!prev_en) last_gap = low_run;
            cap_nib.push_back(phy_nib);
            cap_er.push_back(phy_err);
            low_run = 0;
         end else begin
            if (phy_nib != 4'h0 || phy_err) idle_bad++;
            if (prev_en) frames_done++;
            low_run++;
         end
         if (prev_ready) begin
            if (!phy_en || ((cap_nib.size() - 1 - HEAD) % 2) != 1) ready_bad++;
         end
         prev_en    = phy_en;
         prev_ready = src_ready;
      end
   end

   task automatic push_exp(input logic [3:0] n, input bit e);
      exp_nib.push_back(n);
      exp_er.push_back(e);
   endtask

   // kind: 0 normal, 1 stall at word boundary, 2 stall between nibbles
   task automatic send_frame(input int nbytes, input int err_pos, input int kind,
                             input int at, input bit exact_gap, input string tag);
      logic [7:0] bytes [$];
      int start_frames;
      int mism_nib;
      int mism_er;
      int pre_bad;
      int first_act;
      int first_exp;
      int er_act;
      int er_exp;
      bit hs;
      exp_nib.delete(); exp_er.delete();
      cap_nib.delete(); cap_er.delete();
      start_frames = frames_done;
      for (int i = 0; i < PRE; i++) push_exp(4'h5, 1'b0);
      push_exp(4'hD, 1'b0);
      for (int i = 0; i < nbytes; i++) begin
         bytes.push_back(8'($urandom));
      end
      for (int i = 0; i < nbytes; i++) begin
         if (kind == 1 && i == at) begin
            push_exp(4'h0, 1'b1); push_exp(4'h0, 1'b1);
            break;
         end
         if (kind == 2 && i == at) begin
            push_exp(bytes[i][3:0], i == err_pos); push_exp(4'h0, 1'b1);
            break;
         end
         push_exp(bytes[i][3:0], i == err_pos);
         push_exp(bytes[i][7:4], i == err_pos);
      end
      // drive the source
      for (int i = 0; i < nbytes; i++) begin
         src_data  = bytes[i];
         src_err   = (i == err_pos);
         src_last  = (i == nbytes - 1) && (kind == 0);
         src_valid = 1'b1;
         if (kind == 1 && i == at) begin
            src_valid = 1'b0;
            break;
         end
         if (kind == 2 && i == at) begin
            @(posedge clk); #1;
            src_valid = 1'b0;
            break;
         end
         do begin
            @(negedge clk);
            hs = src_valid && src_ready;
            @(posedge clk); #1;
         end while (!hs);
      end
      src_valid = 1'b0; src_last = 1'b0; src_err = 1'b0;
      while (frames_done == start_frames) @(negedge clk);
      // compare
      check(cap_nib.size() == exp_nib.size(), {tag, " R4 frame length"},
            cap_nib.size(), exp_nib.size());
      pre_bad = 0; mism_nib = 0; mism_er = 0;
      first_act = 0; first_exp = 0; er_act = 0; er_exp = 0;
      for (int k = 0; k < exp_nib.size() && k < cap_nib.size(); k++) begin
         if (k < HEAD) begin
            if (cap_nib[k] !== exp_nib[k] || cap_er[k] !== 1'b0) pre_bad++;
         end else begin
            if (cap_nib[k] !== exp_nib[k]) begin
               if (mism_nib == 0) begin first_act = cap_nib[k]; first_exp = exp_nib[k]; end
               mism_nib++;
            end
            if (cap_er[k] !== exp_er[k]) begin
               if (mism_er == 0) begin er_act = k; er_exp = exp_er[k]; end
               mism_er++;
            end
         end
      end
      check(pre_bad == 0, {tag, " R2 preamble/SFD nibbles"}, pre_bad, 0);
      check(mism_nib == 0, {tag, " R3 payload nibble order"}, first_act, first_exp);
      check(mism_er == 0, {tag, " R6 error flag per nibble (pos/exp)"}, er_act, er_exp);
      if (exact_gap) begin
         check(last_gap == IFG, {tag, " R9 gap exact"}, last_gap, IFG);
      end else begin
         check(last_gap >= IFG, {tag, " R9 gap minimum"}, last_gap, IFG);
      end
   endtask

   initial begin
      void'($urandom(32'd7301));
      rst_n = 1'b0; src_data = 8'h00; src_valid = 1'b0; src_last = 1'b0; src_err = 1'b0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(!phy_en && phy_nib == 4'h0 && !phy_err && !src_ready, "R1 reset state",
            {phy_en, phy_nib, phy_err, src_ready}, 0);
      repeat (40) @(negedge clk);
      check(frames_done == 0 && !phy_en && cap_nib.size() == 0, "R1 no frame without src_valid",
            cap_nib.size(), 0);
      @(posedge clk); #1;

      // directed corners
      send_frame(1, -1, 0, 0, 1'b0, "single-byte");
      send_frame(4, 3, 0, 0, 1'b1, "error-on-last-byte");
      send_frame(3, -1, 0, 0, 1'b1, "clean after error");
      send_frame(5, -1, 1, 2, 1'b1, "R7 stall at boundary");
      send_frame(5, 1, 2, 3, 1'b1, "R8 stall mid-word");
      send_frame(6, 2, 2, 2, 1'b1, "R8 stall on errored word");
      send_frame(2, -1, 0, 0, 1'b1, "back-to-back");

      // constrained random
      for (int f = 0; f < 30; f++) begin
         int  nb;
         int  ep;
         int  kd;
         int  at;
         int  idle;
         nb   = 1 + $urandom_range(0, 19);
         ep   = ($urandom_range(0, 2) == 0) ? $urandom_range(0, nb - 1) : -1;
         kd   = 0;
         at   = 0;
         if (nb >= 2 && $urandom_range(0, 5) == 0) begin
            kd = 1 + $urandom_range(0, 1);
            at = 1 + $urandom_range(0, nb - 2);
         end
         idle = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 40) : 0;
         repeat (idle) @(posedge clk);
         #1;
         send_frame(nb, ep, kd, at, idle == 0, "random");
      end

      check(idle_bad == 0, "R1 idle line quiet", idle_bad, 0);
      check(ready_bad == 0, "R5 ready only on high nibble", ready_bad, 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R4 watchdog expired actual=hung expected=frame end");
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule